// File: doc/BRIEF.md
# Frequent Value Compressed Word Store

This block is the data store of one cache line. Each 32-bit word is kept in one of two forms. A word that equals an entry of a small dictionary of frequent values is kept compressed: only the dictionary index is stored, in an 8-bit low array. Any other word is kept whole: its bits 7:0 go to the low array and its bits 31:8 go to a 24-bit high array. A per-word flag records which form was used, so one line can hold a mix of both forms. The high array is enabled only for uncompressed words, and that is where the energy saving comes from.

Software or a fill engine loads the dictionary through a load port, one entry per beat, before words are written. A write compares the incoming word against every valid dictionary entry in parallel. A read rebuilds the word, either from the dictionary or from the two arrays, and returns it through a registered response. Any dictionary load makes every compressed word in the line stale, because its index may no longer name the same value. Uncompressed words are not affected by a load.

All three data interfaces use valid/ready. A beat transfers on a rising edge where both are high. The load port is always ready. The write port drops `wr_ready` in any cycle where `dl_valid` is high, so a load and a write never land together. The read port accepts a request when the response register is empty, or when the response is being taken in the same cycle. While `rsp_ready` is low, the response holds still and no new read is accepted. The enables of the high array are brought out as plain status pins.

Top module: `fvc_line_store`

## Requirements
- R1: After reset, every word reads back with `rsp_present`=0, `rsp_compressed`=0 and `rsp_data`=0. Every dictionary entry is empty, `rsp_valid` is 0, and `wr_ready` and `dl_ready` are 1.
- R2: A load beat writes `dl_value` into dictionary entry `dl_index` (7 bits, entries 0..127) and marks that entry valid. `dl_ready` is always 1.
- R3: An accepted write whose data equals a valid dictionary entry is stored compressed, using the lowest matching index. `hi_wr_en` stays 0 in the acceptance cycle.
- R4: An accepted write that matches no valid entry is stored uncompressed, with bits 7:0 in the low array and bits 31:8 in the high array. `hi_wr_en` is 1 in the acceptance cycle only.
- R5: Reading a compressed word returns the dictionary value with `rsp_compressed`=1 and `rsp_present`=1. `hi_rd_en` stays 0 in the cycle the read is accepted.
- R6: Reading an uncompressed word returns the exact 32-bit value with `rsp_compressed`=0 and `rsp_present`=1. `hi_rd_en` is 1 in the acceptance cycle.
- R7: Words are independent. A line holding a mix of compressed and uncompressed words returns each word in its own form, and back-to-back reads give one response per cycle.
- R8: Every load beat invalidates all compressed words. They then read with `rsp_present`=0 and `rsp_data`=0. Uncompressed words keep their values.
- R9: While `dl_valid` is 1, `wr_ready` is 0 and a presented write has no effect on the line. `hi_wr_en` stays 0 in that cycle.
- R10: The response appears one cycle after the read is accepted. While `rsp_valid`=1 and `rsp_ready`=0, the response fields hold and `rd_ready` is 0.
- R11: A read and a write to the same word accepted in the same cycle return the word's contents from before the write. The write takes effect for later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dl_valid | input | 1 | Dictionary load beat valid |
| dl_ready | output | 1 | Dictionary load ready (always 1) |
| dl_index | input | 7 | Dictionary entry to load |
| dl_value | input | 32 | Value for that entry |
| wr_valid | input | 1 | Word write valid |
| wr_ready | output | 1 | Word write ready |
| wr_addr | input | 4 | Word position in the line |
| wr_data | input | 32 | Word to store |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_addr | input | 4 | Word position to read |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 32 | Rebuilt word |
| rsp_present | output | 1 | Word holds live data |
| rsp_compressed | output | 1 | Word was stored as a dictionary index |
| hi_wr_en | output | 1 | High array write enable |
| hi_rd_en | output | 1 | High array read enable |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a read and a write to the same word. The bench drives both handshakes together and expects the response to carry the word's old contents and form. A following read must then show the new contents. The second pair is a dictionary load and a write. The bench presents both in one cycle and expects `wr_ready` and `hi_wr_en` low. Later reads must show that the write had no effect, while the load did take effect and made the compressed words stale.

// File: rtl/fvc_pkg.sv
package fvc_pkg;
  localparam int WORD_W = 32;
  localparam int LOW_W  = 8;
  localparam int HIGH_W = WORD_W - LOW_W;

  typedef struct packed {
    logic              present;
    logic              comp;
    logic [WORD_W-1:0] data;
  } fvc_rsp_t;
endpackage

// File: rtl/fvc_dict.sv
module fvc_dict
  import fvc_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [WORD_W-1:0] ld_value,
  input  logic [WORD_W-1:0] cmp_word,
  output logic              cmp_hit,
  output logic [IDX_W-1:0]  cmp_idx,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [WORD_W-1:0] lk_value
);
  logic [WORD_W-1:0] val_q [DEPTH];
  logic [DEPTH-1:0]  ok_q;
  logic [DEPTH-1:0]  hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ok_q <= '0;
      for (int i = 0; i < DEPTH; i++) val_q[i] <= '0;
    end else if (ld_en) begin
      val_q[ld_idx] <= ld_value;
      ok_q[ld_idx]  <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = ok_q[g] && (val_q[g] == cmp_word);
  end

  always_comb begin
    cmp_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) cmp_idx = IDX_W'(i);
    end
  end

  assign cmp_hit  = |hit_vec;
  assign lk_value = val_q[lk_idx];

  // R2
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> ok_q[$past(ld_idx)] && (val_q[$past(ld_idx)] == $past(ld_value)));
endmodule

// File: rtl/fvc_word_store.sv
module fvc_word_store
  import fvc_pkg::*;
#(
  parameter int WORDS  = 16,
  parameter int IDX_W  = 7,
  parameter int ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              wr_comp,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              flush_comp,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_present,
  output logic              rd_comp,
  output logic [LOW_W-1:0]  rd_low,
  output logic [HIGH_W-1:0] rd_high,
  output logic              hi_wr_en,
  output logic              hi_rd_en
);
  logic [LOW_W-1:0]  low_q  [WORDS];
  logic [HIGH_W-1:0] high_q [WORDS];
  logic [WORDS-1:0]  comp_q;
  logic [WORDS-1:0]  live_q;
  logic [LOW_W-1:0]  low_d;

  assign hi_wr_en = wr_en & ~wr_comp;
  assign low_d    = wr_comp ? LOW_W'(wr_idx) : wr_word[LOW_W-1:0];

  // low array: written on every accepted write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) low_q[i] <= '0;
    end else if (wr_en) begin
      low_q[wr_addr] <= low_d;
    end
  end

  // high array: written only for words that missed the dictionary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) high_q[i] <= '0;
    end else if (hi_wr_en) begin
      high_q[wr_addr] <= wr_word[WORD_W-1:LOW_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      comp_q <= '0;
      live_q <= '0;
    end else begin
      if (flush_comp) live_q <= live_q & ~comp_q;
      if (wr_en) begin
        live_q[wr_addr] <= 1'b1;
        comp_q[wr_addr] <= wr_comp;
      end
    end
  end

  assign rd_present = live_q[rd_addr];
  assign rd_comp    = live_q[rd_addr] & comp_q[rd_addr];
  assign rd_low     = low_q[rd_addr];
  assign hi_rd_en   = rd_en & live_q[rd_addr] & ~comp_q[rd_addr];
  assign rd_high    = hi_rd_en ? high_q[rd_addr] : '0;

  // R3
  comp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_comp |=> comp_q[$past(wr_addr)] && live_q[$past(wr_addr)]
                         && (low_q[$past(wr_addr)] == LOW_W'($past(wr_idx))));
  // R4
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_comp |=> !comp_q[$past(wr_addr)]
                          && ({high_q[$past(wr_addr)], low_q[$past(wr_addr)]} == $past(wr_word)));
  // R8
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_comp && !wr_en |=> (live_q & comp_q) == '0);
endmodule

// File: rtl/fvc_line_store.sv
module fvc_line_store
  import fvc_pkg::*;
#(
  parameter int WORDS      = 16,
  parameter int DICT_DEPTH = 128,
  parameter int ADDR_W     = $clog2(WORDS),
  parameter int IDX_W      = $clog2(DICT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dl_valid,
  output logic              dl_ready,
  input  logic [IDX_W-1:0]  dl_index,
  input  logic [WORD_W-1:0] dl_value,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_present,
  output logic              rsp_compressed,
  output logic              hi_wr_en,
  output logic              hi_rd_en
);
  logic              dl_fire, wr_fire, rd_fire;
  logic              cmp_hit;
  logic [IDX_W-1:0]  cmp_idx;
  logic [WORD_W-1:0] lk_value;
  logic              s_present, s_comp;
  logic [LOW_W-1:0]  s_low;
  logic [HIGH_W-1:0] s_high;
  fvc_rsp_t          rsp_d, rsp_q;

  assign dl_ready = 1'b1;
  assign dl_fire  = dl_valid;
  assign wr_ready = ~dl_valid;
  assign wr_fire  = wr_valid & wr_ready;
  assign rd_ready = ~rsp_valid | rsp_ready;
  assign rd_fire  = rd_valid & rd_ready;

  fvc_dict #(.DEPTH(DICT_DEPTH), .IDX_W(IDX_W)) u_dict (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (dl_fire),
    .ld_idx   (dl_index),
    .ld_value (dl_value),
    .cmp_word (wr_data),
    .cmp_hit  (cmp_hit),
    .cmp_idx  (cmp_idx),
    .lk_idx   (s_low[IDX_W-1:0]),
    .lk_value (lk_value)
  );

  fvc_word_store #(.WORDS(WORDS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_fire),
    .wr_addr    (wr_addr),
    .wr_word    (wr_data),
    .wr_comp    (cmp_hit),
    .wr_idx     (cmp_idx),
    .flush_comp (dl_fire),
    .rd_en      (rd_fire),
    .rd_addr    (rd_addr),
    .rd_present (s_present),
    .rd_comp    (s_comp),
    .rd_low     (s_low),
    .rd_high    (s_high),
    .hi_wr_en   (hi_wr_en),
    .hi_rd_en   (hi_rd_en)
  );

  always_comb begin
    rsp_d.present = s_present;
    rsp_d.comp    = s_comp;
    if (!s_present)  rsp_d.data = '0;
    else if (s_comp) rsp_d.data = lk_value;
    else             rsp_d.data = {s_high, s_low};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_q     <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_q     <= rsp_d;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_data       = rsp_q.data;
  assign rsp_present    = rsp_q.present;
  assign rsp_compressed = rsp_q.comp;

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data)
                                && $stable(rsp_present) && $stable(rsp_compressed));
  // R6
  full_read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd_en |=> rsp_valid && rsp_present && !rsp_compressed);
  // R9
  load_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dl_valid && wr_valid |-> !hi_wr_en);
  // R5
  comp_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire && s_comp |-> !hi_rd_en);
endmodule

// File: tb/fvc_line_store_test.sv
module fvc_line_store_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dl_valid = 1'b0, wr_valid = 1'b0, rd_valid = 1'b0, rsp_ready = 1'b1;
  logic [6:0]  dl_index = '0;
  logic [31:0] dl_value = '0, wr_data = '0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic        dl_ready, wr_ready, rd_ready, rsp_valid, rsp_present, rsp_compressed;
  logic        hi_wr_en, hi_rd_en;
  logic [31:0] rsp_data;

  always #2.5 clk = ~clk;

  fvc_line_store uut (
    .clk(clk), .rst_n(rst_n),
    .dl_valid(dl_valid), .dl_ready(dl_ready), .dl_index(dl_index), .dl_value(dl_value),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_present(rsp_present), .rsp_compressed(rsp_compressed),
    .hi_wr_en(hi_wr_en), .hi_rd_en(hi_rd_en)
  );

  typedef struct {
    logic [33:0] exp;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          total = 0, fails = 0, cyc = 0;
  logic        d_ok [128];
  logic [31:0] d_val [128];
  logic        m_live [16];
  logic        m_comp [16];
  logic [31:0] m_data [16];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit dict_hit(input logic [31:0] v);
    for (int i = 0; i < 128; i++) if (d_ok[i] && d_val[i] == v) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [33:0] model_rd(input int a);
    if (!m_live[a]) return 34'd0;
    return {1'b1, m_comp[a], m_data[a]};
  endfunction

  task automatic model_wr(input int a, input logic [31:0] v);
    m_comp[a] = dict_hit(v);
    m_live[a] = 1'b1;
    m_data[a] = v;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // monitor: pops one expectation per completed response handshake
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10 unexpected response", {30'd0, rsp_present, rsp_compressed, rsp_data}, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({rsp_present, rsp_compressed, rsp_data} == e.exp, e.req,
              {30'd0, rsp_present, rsp_compressed, rsp_data}, {30'd0, e.exp});
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d cycles", cyc, 20000);
      summary();
    end
  end

  task automatic do_load(input int idx, input logic [31:0] v);
    dl_valid = 1'b1; dl_index = 7'(idx); dl_value = v;
    @(negedge clk);
    check(dl_ready == 1'b1, "R2 dl_ready", {63'd0, dl_ready}, 64'd1);
    @(posedge clk); #1;
    dl_valid = 1'b0;
    d_ok[idx] = 1'b1; d_val[idx] = v;
    for (int a = 0; a < 16; a++) if (m_comp[a]) m_live[a] = 1'b0;
  endtask

  task automatic do_write(input int a, input logic [31:0] v, input string req);
    bit exp_hi;
    exp_hi = !dict_hit(v);
    wr_valid = 1'b1; wr_addr = 4'(a); wr_data = v;
    @(negedge clk);
    check(wr_ready == 1'b1 && hi_wr_en == exp_hi, req, {62'd0, wr_ready, hi_wr_en}, {62'd0, 1'b1, exp_hi});
    @(posedge clk); #1;
    wr_valid = 1'b0;
    model_wr(a, v);
    @(negedge clk);
    check(hi_wr_en == 1'b0, {req, " enable pulse"}, {63'd0, hi_wr_en}, 64'd0);
    @(posedge clk); #1;
  endtask

  task automatic do_read(input int a, input string req);
    bit exp_hi;
    exp_t e;
    e.exp = model_rd(a); e.req = req;
    sb.push_back(e);
    exp_hi = m_live[a] && !m_comp[a];
    rd_valid = 1'b1; rd_addr = 4'(a);
    @(negedge clk);
    check(rd_ready == 1'b1 && hi_rd_en == exp_hi, {req, " hi_rd_en"}, {62'd0, rd_ready, hi_rd_en}, {62'd0, 1'b1, exp_hi});
    @(posedge clk); #1;
    rd_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin d_ok[i] = 1'b0; d_val[i] = '0; end
    for (int a = 0; a < 16; a++) begin m_live[a] = 1'b0; m_comp[a] = 1'b0; m_data[a] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0 && wr_ready && dl_ready, "R1 reset outputs",
          {61'd0, rsp_valid, wr_ready, dl_ready}, 64'd3);
    @(posedge clk); #1;
    do_read(3, "R1 empty word");
    do_read(0, "R1 empty word 0");
    // zero matches no entry while the dictionary is empty
    do_write(6, 32'h0000_0000, "R4 zero before load");

    do_load(0, 32'h0000_0000);
    do_load(1, 32'hFFFF_FFFF);
    do_load(2, 32'h0000_0001);
    do_load(77, 32'hDEAD_BEEF);
    do_load(127, 32'h1234_5678);
    do_load(100, 32'hFFFF_FFFF); // duplicate value, lower index 1 wins

    do_write(0, 32'hFFFF_FFFF, "R3 compressed write");
    do_write(1, 32'hCAFE_F00D, "R4 full write");
    do_write(2, 32'h0000_0000, "R3 compressed zero");
    do_write(3, 32'h1234_5678, "R3 top index");
    do_write(4, 32'hDEAD_BEEF, "R3 mid index");
    do_write(5, 32'h0000_00AB, "R4 narrow full");
    do_write(15, 32'hA5A5_A5A5, "R4 last word");

    do_read(0, "R5 compressed read");
    do_read(1, "R6 full read");
    do_read(2, "R5 compressed zero");
    do_read(3, "R5 index 127");
    do_read(4, "R5 index 77");
    do_read(5, "R6 narrow value");
    do_read(15, "R6 last word");
    do_read(6, "R6 zero stored whole");
    do_read(9, "R7 untouched word");
    repeat (2) @(posedge clk); #1;

    // R7 back-to-back reads, one per cycle
    for (int a = 0; a < 6; a++) begin
      exp_t e;
      e.exp = model_rd(a); e.req = "R7 streaming read";
      sb.push_back(e);
      rd_valid = 1'b1; rd_addr = 4'(a);
      @(posedge clk); #1;
    end
    rd_valid = 1'b0;
    repeat (2) @(posedge clk); #1;

    // R10 back-pressure on the response
    rsp_ready = 1'b0;
    rd_valid = 1'b1; rd_addr = 4'd1;
    @(posedge clk); #1;
    rd_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(rsp_valid && !rd_ready && rsp_data == 32'hCAFE_F00D && !rsp_compressed,
            "R10 held response", {30'd0, rsp_valid, rd_ready, rsp_data, rsp_compressed, 1'b0},
            {30'd0, 1'b1, 1'b0, 32'hCAFE_F00D, 2'b00});
      @(posedge clk); #1;
    end
    begin
      exp_t e;
      e.exp = model_rd(1); e.req = "R10 released response";
      sb.push_back(e);
    end
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 response drained", {63'd0, rsp_valid}, 64'd0);
    @(posedge clk); #1;

    // R11 read and write of the same word in one cycle
    begin
      exp_t e;
      e.exp = model_rd(1); e.req = "R11 read sees old word";
      sb.push_back(e);
    end
    rd_valid = 1'b1; rd_addr = 4'd1;
    wr_valid = 1'b1; wr_addr = 4'd1; wr_data = 32'h0000_0001;
    @(negedge clk);
    check(hi_rd_en && !hi_wr_en, "R11 enables", {62'd0, hi_rd_en, hi_wr_en}, 64'd2);
    @(posedge clk); #1;
    rd_valid = 1'b0; wr_valid = 1'b0;
    model_wr(1, 32'h0000_0001);
    do_read(1, "R11 new word visible");

    // R9 load and write presented together
    dl_valid = 1'b1; dl_index = 7'd9; dl_value = 32'h0000_0055;
    wr_valid = 1'b1; wr_addr = 4'd5; wr_data = 32'h0000_0077;
    @(negedge clk);
    check(!wr_ready && !hi_wr_en, "R9 write stalled", {62'd0, wr_ready, hi_wr_en}, 64'd0);
    @(posedge clk); #1;
    dl_valid = 1'b0; wr_valid = 1'b0;
    d_ok[9] = 1'b1; d_val[9] = 32'h0000_0055;
    for (int a = 0; a < 16; a++) if (m_comp[a]) m_live[a] = 1'b0;

    do_read(5, "R9 write had no effect");
    do_read(0, "R8 compressed word stale");
    do_read(1, "R8 compressed word stale");
    do_read(4, "R8 compressed word stale");
    do_read(15, "R8 full word kept");
    do_read(6, "R8 full zero kept");

    do_write(7, 32'h0000_0055, "R2 new entry compresses");
    do_write(0, 32'hFFFF_FFFF, "R3 rewrite after load");
    do_read(7, "R2 read via new entry");
    do_read(0, "R5 rewritten word");

    repeat (4) @(posedge clk);
    check(sb.size() == 0, "R7 all responses seen", 64'(sb.size()), 64'd0);
    summary();
  end
endmodule